// File: doc/BRIEF.md
# Oversampled Optical Frame Receiver with Majority Decoding

This block recovers bytes from a noisy single-wire optical receive line. The line is sampled once per clock, and the clock runs at four times the bit rate. After the line has been seen low, the receiver waits for a run of eight high samples that marks the start of a frame. It then collects the following samples in groups of four, one group per data bit. Each group is reduced to a single bit by a majority vote. A group that splits evenly is decoded as 0 and marks the frame as damaged.

After eight groups the frame is complete. A clean frame updates the byte output, pulses a valid strobe and raises an acknowledge line for one bit period, which the return link carries back to the sender. A damaged frame only pulses an error flag. In both cases the receiver then waits for the line to go low again before it looks for the next start marker.

The controller has four states. WAIT_LOW holds until the synchronised line reads 0. HUNT counts consecutive high samples, clears the count on any low sample, and moves to DATA on the eighth high sample. DATA collects groups and leaves after the eighth group: it goes to ACK when the frame is clean and back to WAIT_LOW when it is not. ACK lasts four cycles and then returns to WAIT_LOW.

Top module: `optrx_frame_rx`

## Requirements
- R1: `rx_line` passes through two synchronising flip-flops. A sample driven before clock edge k is consumed by the controller at edge k+2.
- R2: A frame starts only after 8 consecutive high consumed samples that follow a low sample. A shorter high run followed by a low sample starts nothing.
- R3: The first sample after the eighth marker sample opens the group for data bit 0. Every 4 consecutive samples form one bit. Bits arrive D0 first, and `byte_out[i]` holds Di.
- R4: A group with 3 or 4 ones decodes to 1. A group with 3 or 4 zeros decodes to 0.
- R5: A group with exactly 2 ones decodes to 0 and marks the whole frame as erroneous.
- R6: A clean frame loads `byte_out` and pulses `byte_valid` high for exactly one cycle. Both happen at the edge that consumes the last sample of D7.
- R7: For a clean frame, `ack_out` rises at that same edge and stays high for exactly 4 cycles.
- R8: An erroneous frame pulses `frame_err` for one cycle at the edge that consumes the last sample of D7. `byte_out` keeps its value, and neither `byte_valid` nor `ack_out` is raised.
- R9: After a frame ends (after ACK, or after an error), no new frame starts until a low sample has been consumed. A line held high does not retrigger.
- R10: While `rst_n` is low, `byte_out` is 0 and `byte_valid`, `frame_err` and `ack_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Raw optical receive line |
| byte_out | output | DATA_BITS (8) | Last byte recovered from a clean frame |
| byte_valid | output | 1 | One-cycle strobe when byte_out is updated |
| frame_err | output | 1 | One-cycle strobe for a frame with a tied group |
| ack_out | output | 1 | Acknowledge to the return link, high for one bit period |

## Verification
Every result of this block comes out on the edge that consumes a given sample, and the sample entering `rx_line` is consumed two edges later. So the valid strobe, the error strobe, the new byte and the rising acknowledge are all due at the edge that consumes the last sample of D7, which is two edges after that sample was driven. The acknowledge then stays high for the next three cycles. The bench runs its reference model on a two-entry delay line of the driven samples, one step per edge. It compares every output half a cycle after each edge, so each result is checked in the exact cycle it is due, and one cycle early or late counts as a miscompare.

// File: rtl/optrx_pkg.sv
package optrx_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_LOW,
        ST_HUNT,
        ST_DATA,
        ST_ACK
    } rx_state_e;
endpackage

// File: rtl/optrx_sync.sv
module optrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[gi] <= 1'b0;
                else if (gi == 0) chain_q[gi] <= din;
                else chain_q[gi] <= chain_q[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/optrx_vote.sv
module optrx_vote #(
    parameter int N = 4
) (
    input  logic [N-1:0] samples,
    output logic         bit_val,
    output logic         tie
);
    localparam int CW = $clog2(N + 1);
    logic [CW:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < N; i++) ones = ones + (CW+1)'(samples[i]);
    end

    // R4: strict majority of ones gives 1; R5: an even split gives 0 plus tie
    assign bit_val = (32'(ones) * 2) > N;
    assign tie     = (32'(ones) * 2) == N;

    always_comb begin
        if (tie) assert (!bit_val) else $error("tie decoded as one");
    end
endmodule

// File: rtl/optrx_frame_rx.sv
module optrx_frame_rx #(
    parameter int SPB         = 4,
    parameter int MARK_LEN    = 8,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] byte_out,
    output logic                 byte_valid,
    output logic                 frame_err,
    output logic                 ack_out
);
    import optrx_pkg::*;

    localparam int SW = $clog2(SPB + 1);
    localparam int MW = $clog2(MARK_LEN + 1);
    localparam int BW = $clog2(DATA_BITS + 1);

    rx_state_e st_q, st_d;
    logic rx_s;
    logic [MW-1:0] run_q;
    logic [SW-1:0] samp_q, ack_q;
    logic [BW-1:0] bit_q;
    logic [SPB-1:0] grp_q;
    logic [DATA_BITS-1:0] shift_q;
    logic err_q;
    logic vote_bit, vote_tie;
    logic grp_done, frame_done, frame_bad;

    // R1: two-stage synchroniser on the raw line
    optrx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
    );

    optrx_vote #(.N(SPB)) vote_i (
        .samples({grp_q[SPB-2:0], rx_s}), .bit_val(vote_bit), .tie(vote_tie)
    );

    assign grp_done   = (st_q == ST_DATA) && (samp_q == SW'(SPB-1));
    assign frame_done = grp_done && (bit_q == BW'(DATA_BITS-1));
    assign frame_bad  = err_q | vote_tie;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WAIT_LOW: if (!rx_s) st_d = ST_HUNT;
            ST_HUNT:     if (rx_s && run_q == MW'(MARK_LEN-1)) st_d = ST_DATA;
            ST_DATA:     if (frame_done) st_d = frame_bad ? ST_WAIT_LOW : ST_ACK;
            ST_ACK:      if (ack_q == SW'(SPB-1)) st_d = ST_WAIT_LOW;
            default:     st_d = ST_WAIT_LOW;
        endcase
    end

    // state register and frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_WAIT_LOW;
            run_q   <= '0;
            samp_q  <= '0;
            ack_q   <= '0;
            bit_q   <= '0;
            grp_q   <= '0;
            shift_q <= '0;
            err_q   <= 1'b0;
        end else begin
            st_q  <= st_d;
            run_q <= (st_q == ST_HUNT && rx_s) ? run_q + 1'b1 : '0;
            ack_q <= (st_q == ST_ACK) ? ack_q + 1'b1 : '0;
            if (st_q == ST_DATA) begin
                grp_q  <= {grp_q[SPB-2:0], rx_s};
                samp_q <= grp_done ? '0 : samp_q + 1'b1;
                if (grp_done) begin
                    bit_q   <= bit_q + 1'b1;
                    shift_q <= {vote_bit, shift_q[DATA_BITS-1:1]};
                    if (vote_tie) err_q <= 1'b1;
                end
            end else begin
                samp_q <= '0;
                bit_q  <= '0;
                err_q  <= 1'b0;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_out   <= '0;
            byte_valid <= 1'b0;
            frame_err  <= 1'b0;
            ack_out    <= 1'b0;
        end else begin
            byte_valid <= frame_done && !frame_bad;
            frame_err  <= frame_done && frame_bad;
            ack_out    <= (st_d == ST_ACK);
            if (frame_done && !frame_bad)
                byte_out <= {vote_bit, shift_q[DATA_BITS-1:1]};
        end
    end

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
    p_byte_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(byte_out) |-> byte_valid);
    p_valid_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && frame_err));
    p_ack_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_out) |-> byte_valid);
    p_ack_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_out) |-> ($past(ack_out, 4) && !$past(ack_out, 5)));
    p_err_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !ack_out);
    p_data_from_hunt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA && $past(st_q) != ST_DATA) |-> $past(st_q) == ST_HUNT);
endmodule

// File: tb/optrx_frame_rx_tb.sv
module optrx_frame_rx_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_line = 1'b0;
    logic [7:0] byte_out;
    logic byte_valid, frame_err, ack_out;

    int vectors = 0;
    int fails = 0;
    int n_valid = 0;
    int n_err = 0;
    logic [7:0] last_byte = 8'h00;

    // reference model state
    int m_st = 0;  // 0 wait low, 1 hunt, 2 data, 3 ack
    int m_run = 0, m_ns = 0, m_nb = 0, m_ak = 0;
    bit m_ferr = 0;
    int m_grp[4];
    logic [7:0] m_acc = 8'h00;
    logic [7:0] e_byte = 8'h00;
    bit e_valid = 0, e_err = 0, e_ack = 0;
    bit d1 = 0, d2 = 0;

    always #10 clk = ~clk;

    optrx_frame_rx dut_i (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .byte_out(byte_out), .byte_valid(byte_valid),
        .frame_err(frame_err), .ack_out(ack_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one model step for one clock edge, consuming the synchronised sample
    task automatic model_step(input bit v);
        int ones;
        e_valid = 0;
        e_err = 0;
        case (m_st)
            0: if (!v) begin m_st = 1; m_run = 0; end
            1: begin
                if (v) begin
                    m_run++;
                    if (m_run == 8) begin
                        m_st = 2; m_ns = 0; m_nb = 0; m_ferr = 0;
                    end
                end else m_run = 0;
            end
            2: begin
                m_grp[m_ns] = v;
                m_ns++;
                if (m_ns == 4) begin
                    ones = m_grp[0] + m_grp[1] + m_grp[2] + m_grp[3];
                    m_acc[m_nb] = (ones >= 3);
                    if (ones == 2) m_ferr = 1;
                    m_ns = 0;
                    m_nb++;
                    if (m_nb == 8) begin
                        if (m_ferr) begin e_err = 1; m_st = 0; end
                        else begin e_valid = 1; e_byte = m_acc; m_st = 3; m_ak = 0; end
                    end
                end
            end
            default: begin
                m_ak++;
                if (m_ak == 4) m_st = 0;
            end
        endcase
        e_ack = (m_st == 3);
    endtask

    // compare outputs from the previous edge, then drive one sample
    task automatic drive(input bit v);
        @(negedge clk);
        chk("R3", "byte_out", byte_out, e_byte);
        chk("R6", "byte_valid", byte_valid, e_valid);
        chk("R5", "frame_err", frame_err, e_err);
        chk("R7", "ack_out", ack_out, e_ack);
        if (byte_valid) begin n_valid++; last_byte = byte_out; end
        if (frame_err) n_err++;
        rx_line = v;
        rst_n = 1'b1;
        model_step(d2);  // R1: consumed two edges after being driven
        d2 = d1;
        d1 = v;
    endtask

    task automatic hold(input bit v, input int n);
        for (int i = 0; i < n; i++) drive(v);
    endtask

    // glitch: one flipped sample in that bit's group; tie: two flipped
    task automatic send_frame(input logic [7:0] b, input logic [7:0] glitch, input logic [7:0] tie);
        hold(1'b0, 4);
        hold(1'b1, 8);
        for (int i = 0; i < 8; i++) begin
            for (int s = 0; s < 4; s++) begin
                bit v;
                v = b[i];
                if (glitch[i] && s == 2) v = ~v;
                if (tie[i] && (s == 1 || s == 2)) v = ~v;
                drive(v);
            end
        end
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int v0, e0;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10", "reset byte_out", byte_out, 0);
        chk("R10", "reset strobes", {byte_valid, frame_err, ack_out}, 0);

        // R3 R6 R7: clean frame
        send_frame(8'h1C, 8'h00, 8'h00);
        hold(1'b0, 12);
        chk("R3", "byte 1C", last_byte, 8'h1C);

        // R4: one bad sample in every group still decodes
        send_frame(8'hA5, 8'hFF, 8'h00);
        hold(1'b0, 12);
        chk("R4", "majority byte", last_byte, 8'hA5);

        // R5 R8: tied group -> error, byte kept, no valid
        v0 = n_valid; e0 = n_err;
        send_frame(8'h3C, 8'h00, 8'h04);
        hold(1'b0, 12);
        chk("R8", "valid after error frame", n_valid, v0);
        chk("R5", "error count", n_err, e0 + 1);
        chk("R8", "byte kept", byte_out, 8'hA5);

        // R2: seven-sample marker starts nothing
        v0 = n_valid; e0 = n_err;
        hold(1'b0, 4);
        hold(1'b1, 7);
        hold(1'b0, 40);
        chk("R2", "short marker", n_valid + n_err, v0 + e0);

        // R9: line held high after a frame does not retrigger
        v0 = n_valid;
        send_frame(8'hFF, 8'h00, 8'h00);
        hold(1'b1, 60);
        chk("R9", "no retrigger", n_valid, v0 + 1);
        hold(1'b0, 8);

        // back-to-back frames with short gaps
        send_frame(8'h81, 8'h00, 8'h00);
        hold(1'b0, 6);
        chk("R6", "byte 81", last_byte, 8'h81);
        send_frame(8'h7E, 8'h5A, 8'h00);
        hold(1'b0, 8);
        chk("R4", "byte 7E", last_byte, 8'h7E);
        send_frame(8'h00, 8'h00, 8'h00);
        hold(1'b0, 8);
        chk("R3", "byte 00", last_byte, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule